// File: doc/BRIEF.md
# Coprocessor Load/Store Address Generator

This block turns one coprocessor load/store instruction into the address of its first transfer word and, where the indexing mode asks for it, the value to write back into the base register. The core presents the instruction's five mode bits, the full instruction word and the current contents of the base register, and raises a one-cycle strobe. One clock later the block returns the start address, a writeback enable with its value, the decoded register and coprocessor fields, and the indexing mode.

The immediate in the low byte is a word count, so the byte offset is that count times four. The up bit chooses whether the offset is added or subtracted. The pre-index and writeback bits together pick one of four modes. The one combination that cannot be a valid load/store (no pre-index, no writeback, down) is reclaimed for the two-register transfer extension space. For that space the block reports the transfer direction, the opcode and the coprocessor register fields, and it flags a register choice of 15 as unpredictable. It produces no address and no writeback for such an instruction. Stepping through multi-word transfers is left to the caller.

Top module: `cpx_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid, wb_en, ext_space, unpredictable and start_addr are all 0.
- R2: out_valid is high for exactly the cycle after each cycle in which in_valid is high. Without a strobe, the result outputs keep their last values.
- R3: base_idx is instr[19:16], creg_idx is instr[15:12] and cp_id is instr[11:8]. is_long echoes long_xfer and is_load echoes load. instr[31:20] has no effect.
- R4: The offset is instr[7:0] multiplied by 4. up=1 adds it to base_val and up=0 subtracts it, both modulo 2^32.
- R5: pre_idx=0, wback=0 with up=1 (unindexed): start_addr = base_val, wb_en = 0, wb_val = 0.
- R6: pre_idx=0, wback=1 (post-indexed): start_addr = base_val, wb_en = 1, wb_val = base_val ± offset.
- R7: pre_idx=1, wback=0 (offset): start_addr = base_val ± offset, wb_en = 0, wb_val = 0.
- R8: pre_idx=1, wback=1 (pre-indexed): start_addr and wb_val both equal base_val ± offset, and wb_en = 1.
- R9: pre_idx=0, wback=0, up=0 sets ext_space=1, with start_addr=0 and wb_en=0. ext_read is load in that case and 0 otherwise. ext_op is instr[7:4] and ext_crm is instr[3:0].
- R10: unpredictable=1 only when ext_space=1 and either instr[15:12] or instr[19:16] equals 15.
- R11: addr_mode is {pre_idx,wback}: 0 unindexed, 1 post, 2 offset, 3 pre. It reads 0 in the extension space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction strobe |
| pre_idx | input | 1 | Pre-index bit |
| up | input | 1 | Add (1) or subtract (0) offset |
| long_xfer | input | 1 | Long-transfer bit |
| wback | input | 1 | Writeback bit |
| load | input | 1 | Load (1) or store (0) |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Current base register value |
| out_valid | output | 1 | Result valid |
| start_addr | output | 32 | First transfer address |
| wb_en | output | 1 | Base writeback enable |
| wb_val | output | 32 | Base writeback value |
| addr_mode | output | 2 | Indexing mode |
| base_idx | output | 4 | Base register index |
| creg_idx | output | 4 | Coprocessor register / Rd index |
| cp_id | output | 4 | Coprocessor number |
| is_long | output | 1 | Long-transfer echo |
| is_load | output | 1 | Direction echo |
| ext_space | output | 1 | Two-register transfer extension |
| ext_read | output | 1 | Extension transfer reads coprocessor |
| ext_op | output | 4 | Extension opcode field |
| ext_crm | output | 4 | Extension CRm field |
| unpredictable | output | 1 | Extension register 15 used |

## Verification
The bench builds the block with its defaults: 32-bit addresses, an 8-bit immediate scaled by a shift of 2, and the shared add/subtract adder. These values let a full-scale immediate of 255 words push the sum past 2^32 in both directions, so both the wrap on addition and the borrow on subtraction are checked. Register index 15 can appear in either extension field, which covers the unpredictable flag from both sides.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

   localparam int INSTR_W   = 32;
   localparam int REG_IDX_W = 4;
   localparam int RN_LSB    = 16;
   localparam int RD_LSB    = 12;
   localparam int CP_LSB    = 8;
   localparam int XOP_LSB   = 4;
   localparam int CRM_LSB   = 0;
   localparam logic [REG_IDX_W-1:0] PC_IDX = '1;

   typedef enum logic [1:0] {
      IDX_NONE = 2'b00,
      IDX_POST = 2'b01,
      IDX_OFFS = 2'b10,
      IDX_PRE  = 2'b11
   } idx_mode_e;

   typedef struct packed {
      logic [REG_IDX_W-1:0] base_idx;
      logic [REG_IDX_W-1:0] creg_idx;
      logic [REG_IDX_W-1:0] cp_id;
      logic [REG_IDX_W-1:0] xop;
      logic [REG_IDX_W-1:0] crm;
   } fields_t;

endpackage

// File: rtl/cpx_field_decode.sv
module cpx_field_decode
   import cpx_pkg::*;
#(
   parameter int IMM_W = 8
) (
   input  logic [INSTR_W-1:0] instr,
   output fields_t            flds,
   output logic [IMM_W-1:0]   imm
);

   localparam int USED_W = RN_LSB + REG_IDX_W;

   logic unused_hi;
   assign unused_hi = ^instr[INSTR_W-1:USED_W];

   assign flds.base_idx = instr[RN_LSB  +: REG_IDX_W];
   assign flds.creg_idx = instr[RD_LSB  +: REG_IDX_W];
   assign flds.cp_id    = instr[CP_LSB  +: REG_IDX_W];
   assign flds.xop      = instr[XOP_LSB +: REG_IDX_W];
   assign flds.crm      = instr[CRM_LSB +: REG_IDX_W];
   assign imm           = instr[IMM_W-1:0];

endmodule

// File: rtl/cpx_mode_select.sv
module cpx_mode_select
   import cpx_pkg::*;
(
   input  logic      pre_idx,
   input  logic      up,
   input  logic      wback,
   input  logic      load,
   input  fields_t   flds,
   output idx_mode_e mode,
   output logic      ext,
   output logic      ext_rd,
   output logic      unp
);

   always_comb begin
      ext    = ~pre_idx & ~wback & ~up;
      mode   = ext ? IDX_NONE : idx_mode_e'({pre_idx, wback});
      ext_rd = ext & load;
      unp    = ext & ((flds.creg_idx == PC_IDX) | (flds.base_idx == PC_IDX));
   end

endmodule

// File: rtl/cpx_index_calc.sv
module cpx_index_calc
   import cpx_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int IMM_W        = 8,
   parameter int SCALE_SH     = 2,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IMM_W-1:0]  imm,
   input  logic              up,
   input  logic              ext,
   input  idx_mode_e         mode,
   output logic [ADDR_W-1:0] addr,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_val
);

   localparam int PAD_W = ADDR_W - IMM_W;

   logic [ADDR_W-1:0] ofs;
   logic [ADDR_W-1:0] moved;

   assign ofs = {{PAD_W{1'b0}}, imm} << SCALE_SH;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [ADDR_W-1:0] opnd;
         assign opnd  = up ? ofs : ~ofs;
         assign moved = base + opnd + {{(ADDR_W-1){1'b0}}, ~up};
      end else begin : g_split
         logic [ADDR_W-1:0] plus_v;
         logic [ADDR_W-1:0] minus_v;
         assign plus_v  = base + ofs;
         assign minus_v = base - ofs;
         assign moved   = up ? plus_v : minus_v;
      end
   endgenerate

   always_comb begin
      addr   = '0;
      wb_en  = 1'b0;
      wb_val = '0;
      if (!ext) begin
         unique case (mode)
            IDX_NONE: addr = base;
            IDX_POST: begin
               addr   = base;
               wb_en  = 1'b1;
               wb_val = moved;
            end
            IDX_OFFS: addr = moved;
            IDX_PRE: begin
               addr   = moved;
               wb_en  = 1'b1;
               wb_val = moved;
            end
            default: addr = '0;
         endcase
      end
   end

endmodule

// File: rtl/cpx_addr_gen.sv
module cpx_addr_gen
   import cpx_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int IMM_W        = 8,
   parameter int SCALE_SH     = 2,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              pre_idx,
   input  logic              up,
   input  logic              long_xfer,
   input  logic              wback,
   input  logic              load,
   input  logic [31:0]       instr,
   input  logic [ADDR_W-1:0] base_val,
   output logic              out_valid,
   output logic [ADDR_W-1:0] start_addr,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_val,
   output logic [1:0]        addr_mode,
   output logic [3:0]        base_idx,
   output logic [3:0]        creg_idx,
   output logic [3:0]        cp_id,
   output logic              is_long,
   output logic              is_load,
   output logic              ext_space,
   output logic              ext_read,
   output logic [3:0]        ext_op,
   output logic [3:0]        ext_crm,
   output logic              unpredictable
);

   generate
      if (IMM_W + SCALE_SH > ADDR_W) begin : g_bad_offset
         $error("scaled immediate wider than address");
      end
      if (IMM_W > CP_LSB) begin : g_bad_imm
         $error("immediate overlaps coprocessor field");
      end
      if (INSTR_W != 32) begin : g_bad_instr
         $error("instruction word must be 32 bits");
      end
   endgenerate

   fields_t           flds;
   logic [IMM_W-1:0]  imm;
   idx_mode_e         mode_c;
   logic              ext_c, ext_rd_c, unp_c;
   logic [ADDR_W-1:0] addr_c, wbv_c;
   logic              wben_c;

   cpx_field_decode #(.IMM_W(IMM_W)) u_dec (
      .instr (instr),
      .flds  (flds),
      .imm   (imm)
   );

   cpx_mode_select u_mode (
      .pre_idx (pre_idx),
      .up      (up),
      .wback   (wback),
      .load    (load),
      .flds    (flds),
      .mode    (mode_c),
      .ext     (ext_c),
      .ext_rd  (ext_rd_c),
      .unp     (unp_c)
   );

   cpx_index_calc #(
      .ADDR_W       (ADDR_W),
      .IMM_W        (IMM_W),
      .SCALE_SH     (SCALE_SH),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_idx (
      .base   (base_val),
      .imm    (imm),
      .up     (up),
      .ext    (ext_c),
      .mode   (mode_c),
      .addr   (addr_c),
      .wb_en  (wben_c),
      .wb_val (wbv_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_addr    <= '0;
         wb_en         <= 1'b0;
         wb_val        <= '0;
         addr_mode     <= IDX_NONE;
         base_idx      <= '0;
         creg_idx      <= '0;
         cp_id         <= '0;
         is_long       <= 1'b0;
         is_load       <= 1'b0;
         ext_space     <= 1'b0;
         ext_read      <= 1'b0;
         ext_op        <= '0;
         ext_crm       <= '0;
         unpredictable <= 1'b0;
      end else if (in_valid) begin
         start_addr    <= addr_c;
         wb_en         <= wben_c;
         wb_val        <= wbv_c;
         addr_mode     <= mode_c;
         base_idx      <= flds.base_idx;
         creg_idx      <= flds.creg_idx;
         cp_id         <= flds.cp_id;
         is_long       <= long_xfer;
         is_load       <= load;
         ext_space     <= ext_c;
         ext_read      <= ext_rd_c;
         ext_op        <= flds.xop;
         ext_crm       <= flds.crm;
         unpredictable <= unp_c;
      end
   end

   assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(start_addr) && $stable(wb_val) && $stable(wb_en)));

   assert_unidx_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pre_idx && !wback && up) |=> (start_addr == $past(base_val) && !wb_en));

   assert_post_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pre_idx && wback) |=> (start_addr == $past(base_val) && wb_en));

   assert_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && wb_en && addr_mode == IDX_PRE) |-> (start_addr == wb_val));

   assert_ext_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pre_idx && !wback && !up) |=> (ext_space && !wb_en && start_addr == '0));

   assert_unp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unpredictable |-> ext_space);

endmodule

// File: tb/cpx_addr_gen_bench.sv
`timescale 1ns/1ps
module cpx_addr_gen_bench;

   typedef struct packed {
      logic        p, u, n, w, l;
      logic [31:0] instr;
      logic [31:0] base;
      logic [31:0] e_addr;
      logic        e_wb;
      logic [31:0] e_wbv;
      logic [1:0]  e_mode;
      logic        e_ext;
      logic        e_unp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VT [NV] = '{
      // R5 unindexed, upper bits set (R3)
      '{1'b0,1'b1,1'b0,1'b0,1'b1, 32'hEC03_5F10, 32'h0000_1000, 32'h0000_1000, 1'b0, 32'h0, 2'd0, 1'b0, 1'b0},
      // R6 post-indexed, add
      '{1'b0,1'b1,1'b1,1'b1,1'b0, 32'h0002_3E04, 32'h0000_2000, 32'h0000_2000, 1'b1, 32'h0000_2010, 2'd1, 1'b0, 1'b0},
      // R6 R4 post-indexed, subtract with borrow
      '{1'b0,1'b0,1'b0,1'b1,1'b1, 32'h0001_1EFF, 32'h0000_0100, 32'h0000_0100, 1'b1, 32'hFFFF_FD04, 2'd1, 1'b0, 1'b0},
      // R7 offset, add
      '{1'b1,1'b1,1'b0,1'b0,1'b0, 32'hED04_0F20, 32'h8000_0000, 32'h8000_0080, 1'b0, 32'h0, 2'd2, 1'b0, 1'b0},
      // R7 offset, subtract
      '{1'b1,1'b0,1'b1,1'b0,1'b1, 32'h0000_7F01, 32'h0000_0010, 32'h0000_000C, 1'b0, 32'h0, 2'd2, 1'b0, 1'b0},
      // R8 R4 pre-indexed, add with wrap
      '{1'b1,1'b1,1'b0,1'b1,1'b1, 32'h000E_2FFF, 32'hFFFF_FF00, 32'h0000_02FC, 1'b1, 32'h0000_02FC, 2'd3, 1'b0, 1'b0},
      // R8 pre-indexed, subtract
      '{1'b1,1'b0,1'b0,1'b1,1'b0, 32'h000D_0F08, 32'h0000_0040, 32'h0000_0020, 1'b1, 32'h0000_0020, 2'd3, 1'b0, 1'b0},
      // R9 extension read, no bad register
      '{1'b0,1'b0,1'b1,1'b0,1'b1, 32'h0005_6F3A, 32'hDEAD_0000, 32'h0, 1'b0, 32'h0, 2'd0, 1'b1, 1'b0},
      // R9 R10 extension write, Rd = 15
      '{1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0002_F712, 32'h1111_1111, 32'h0, 1'b0, 32'h0, 2'd0, 1'b1, 1'b1},
      // R10 load/store with Rn = 15 is not flagged
      '{1'b1,1'b1,1'b0,1'b0,1'b0, 32'h000F_FF00, 32'h0000_1234, 32'h0000_1234, 1'b0, 32'h0, 2'd2, 1'b0, 1'b0},
      // R10 extension read, Rn = 15
      '{1'b0,1'b0,1'b0,1'b0,1'b1, 32'h000F_3F45, 32'h0000_0005, 32'h0, 1'b0, 32'h0, 2'd0, 1'b1, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, pre_idx = 1'b0, up = 1'b0, long_xfer = 1'b0, wback = 1'b0, load = 1'b0;
   logic [31:0] instr = '0, base_val = '0;
   logic        out_valid, wb_en, is_long, is_load, ext_space, ext_read, unpredictable;
   logic [31:0] start_addr, wb_val;
   logic [1:0]  addr_mode;
   logic [3:0]  base_idx, creg_idx, cp_id, ext_op, ext_crm;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cpx_addr_gen u_cpx_addr_gen (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .pre_idx (pre_idx), .up (up),
      .long_xfer (long_xfer), .wback (wback), .load (load), .instr (instr), .base_val (base_val),
      .out_valid (out_valid), .start_addr (start_addr), .wb_en (wb_en), .wb_val (wb_val),
      .addr_mode (addr_mode), .base_idx (base_idx), .creg_idx (creg_idx), .cp_id (cp_id),
      .is_long (is_long), .is_load (is_load), .ext_space (ext_space), .ext_read (ext_read),
      .ext_op (ext_op), .ext_crm (ext_crm), .unpredictable (unpredictable)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      logic [31:0] held_addr, held_wbv;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(out_valid == 1'b0, "R1 out_valid", {31'd0, out_valid}, 32'd0);
      chk(wb_en == 1'b0 && ext_space == 1'b0 && unpredictable == 1'b0, "R1 flags",
          {29'd0, wb_en, ext_space, unpredictable}, 32'd0);
      chk(start_addr == 32'd0, "R1 start_addr", start_addr, 32'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         pre_idx = VT[i].p; up = VT[i].u; long_xfer = VT[i].n; wback = VT[i].w; load = VT[i].l;
         instr = VT[i].instr; base_val = VT[i].base;
         @(negedge clk);
         in_valid = 1'b0;
         chk(out_valid == 1'b1, "R2 out_valid", {31'd0, out_valid}, 32'd1);
         chk(start_addr == VT[i].e_addr, "R5-8 start_addr", start_addr, VT[i].e_addr);
         chk(wb_en == VT[i].e_wb, "R6 wb_en", {31'd0, wb_en}, {31'd0, VT[i].e_wb});
         chk(wb_val == VT[i].e_wbv, "R4 wb_val", wb_val, VT[i].e_wbv);
         chk(addr_mode == VT[i].e_mode, "R11 addr_mode", {30'd0, addr_mode}, {30'd0, VT[i].e_mode});
         chk(base_idx == VT[i].instr[19:16] && creg_idx == VT[i].instr[15:12] && cp_id == VT[i].instr[11:8],
             "R3 fields", {20'd0, base_idx, creg_idx, cp_id}, {20'd0, VT[i].instr[19:8]});
         chk(is_long == VT[i].n && is_load == VT[i].l, "R3 echo",
             {30'd0, is_long, is_load}, {30'd0, VT[i].n, VT[i].l});
         chk(ext_space == VT[i].e_ext, "R9 ext_space", {31'd0, ext_space}, {31'd0, VT[i].e_ext});
         chk(ext_read == (VT[i].e_ext & VT[i].l), "R9 ext_read", {31'd0, ext_read},
             {31'd0, VT[i].e_ext & VT[i].l});
         chk(ext_op == VT[i].instr[7:4] && ext_crm == VT[i].instr[3:0], "R9 ext fields",
             {24'd0, ext_op, ext_crm}, {24'd0, VT[i].instr[7:0]});
         chk(unpredictable == VT[i].e_unp, "R10 unpredictable", {31'd0, unpredictable},
             {31'd0, VT[i].e_unp});
      end

      // R2 hold: new inputs without a strobe have no effect
      held_addr = start_addr;
      held_wbv  = wb_val;
      pre_idx = 1'b1; up = 1'b1; wback = 1'b1; instr = 32'h0003_0F7F; base_val = 32'hABCD_0000;
      @(negedge clk);
      chk(out_valid == 1'b0, "R2 strobe drop", {31'd0, out_valid}, 32'd0);
      @(negedge clk);
      chk(start_addr == held_addr, "R2 hold addr", start_addr, held_addr);
      chk(wb_val == held_wbv && ext_space == 1'b1, "R2 hold wb", wb_val, held_wbv);

      // R2 back-to-back strobes
      in_valid = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b1 && start_addr == 32'hABCD_01FC, "R8 back-to-back 1", start_addr, 32'hABCD_01FC);
      pre_idx = 1'b0; up = 1'b0; wback = 1'b1; instr = 32'h0003_0F01; base_val = 32'h0000_0000;
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_valid == 1'b1 && wb_val == 32'hFFFF_FFFC, "R6 back-to-back 2", wb_val, 32'hFFFF_FFFC);
      chk(start_addr == 32'd0, "R6 back-to-back addr", start_addr, 32'd0);

      // R1 reset in mid-run
      rst_n = 1'b0;
      #1;
      chk(out_valid == 1'b0 && wb_en == 1'b0 && start_addr == 32'd0, "R1 reassert", start_addr, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule